// File: doc/BRIEF.md
# Interrupt Clear-Pending Register Bank

This block holds the pending and active state of every interrupt handled by one distributor, and gives software a window of 32-bit words onto that state. Reading a word shows which of its 32 interrupts are pending. Writing a word with ones removes the pending state from the selected interrupts: a pending interrupt becomes inactive, and an active-and-pending one becomes active. Zero bits in the write data leave their interrupts alone.

Whether a bit can be seen or cleared depends on several things: the interrupt's ID, whether its word is implemented, whether affinity routing is on, and whether the access is secure. A non-secure access only reaches interrupts that are in the non-secure group or that have been granted non-secure control. Interrupt sources raise pending state through a set input. Acknowledge and completion are also plain inputs, and they move interrupts into and out of the active state. Priority and delivery to processors are handled elsewhere.

Top module: `icp_bank`

## Requirements
- R1: Word n sits at byte address 0x280 + 4n, and interrupt m is bit m MOD 32 of word m DIV 32.
- R2: A read returns 1 in a bit whose interrupt is pending or active-and-pending, and 0 for an inactive or active one. The data appears on `rd_data` with `rd_valid` high in the cycle after the `acc_rd` strobe. `rd_data` is zero whenever `rd_valid` is low.
- R3: Writing 1 to a bit moves a pending interrupt to inactive and an active-and-pending interrupt to active. Writing 1 to an inactive or active interrupt changes nothing, and writing 0 has no effect.
- R4: After reset every interrupt is inactive, `pend_out` and `active_out` are all zero, and every word reads 0.
- R5: Bits for IDs 0 to 15 show their pending state on read, but a write never clears them.
- R6: While `cfg_affinity` is 1, bits for IDs 0 to 31 read as 0 and writes to them are ignored.
- R7: Any word with index above `cfg_words_m1` reads as 0 and ignores writes. The same holds for an address outside the map or not aligned to 4 bytes.
- R8: While `cfg_sec_en` is 1, a non-secure access (`acc_nonsec`=1) sees an interrupt as read-as-zero and write-ignored when both its `irq_ns_group` bit and its `irq_ns_ok` bit are 0. A secure access is not restricted in this way.
- R9: When a set pulse and a clearing write reach the same interrupt in the same cycle, the clear wins. A set still present in the following cycle makes the interrupt pending.
- R10: `irq_set` moves inactive to pending and active to active-and-pending. `irq_activate` moves a pending, not active interrupt to active. `irq_deactivate` moves active to inactive and active-and-pending to pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 12 | Byte address of the access |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data, one clear bit per interrupt |
| acc_nonsec | input | 1 | 1 marks a non-secure access |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | 32 | Read data |
| cfg_words_m1 | input | 5 | Number of implemented words minus one |
| cfg_sec_en | input | 1 | Security support enabled |
| cfg_affinity | input | 1 | Affinity routing enabled |
| irq_ns_group | input | 32*MAX_WORDS | 1 puts the interrupt in the non-secure group |
| irq_ns_ok | input | 32*MAX_WORDS | 1 grants non-secure control of the interrupt |
| irq_set | input | 32*MAX_WORDS | Set-pending pulse per interrupt |
| irq_activate | input | 32*MAX_WORDS | Acknowledge per interrupt |
| irq_deactivate | input | 32*MAX_WORDS | Completion per interrupt |
| pend_out | output | 32*MAX_WORDS | Pending state per interrupt |
| active_out | output | 32*MAX_WORDS | Active state per interrupt |

## Verification
The main stimulus is a one-hot write walked across all 64 interrupts of a two-word build, starting with everything pending. Because each interrupt is cleared on its own, a wrong word or bit mapping shows up, and so does a missing SGI write guard. The same clears are then applied to active-and-pending and active interrupts to confirm that only the pending half of the state is removed. An all-zero write checks that zero bits do nothing.

Bit masks are checked with alternating and banded patterns of group and permission bits, given to both non-secure and secure writes. Separate sequences toggle affinity routing, shrink the implemented word count, and use stray or misaligned addresses, so each access guard is tested apart from the others. A set pulse that lands together with a clear, and then is held for a second cycle, separates clear priority from a lost set.

// File: rtl/icp_pkg.sv
package icp_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 5;
    localparam logic [ADDR_W-1:0] ICP_BASE = 12'h280;
    localparam int SGI_LAST  = 15;
    localparam int PRIV_LAST = 31;

    typedef struct packed {
        logic active;
        logic pending;
    } irq_state_t;

    typedef struct packed {
        logic              hit;
        logic [WORD_W-1:0] word;
    } icp_dec_t;

    // Visibility of one interrupt to the current access.
    function automatic logic irq_visible(input int id, input logic impl,
                                         input logic affinity, input logic sec_en,
                                         input logic nonsec, input logic ns_group,
                                         input logic ns_ok);
        logic priv_hidden;
        logic sec_hidden;
        priv_hidden = affinity && (id <= PRIV_LAST);
        sec_hidden  = sec_en && nonsec && !ns_group && !ns_ok;
        return impl && !priv_hidden && !sec_hidden;
    endfunction

    function automatic logic irq_writable(input int id, input logic vis);
        return vis && (id > SGI_LAST);
    endfunction

    // Next state: completion, acknowledge, set, then clear (clear wins).
    function automatic irq_state_t irq_next(input irq_state_t cur, input logic set,
                                            input logic act, input logic deact,
                                            input logic clr);
        irq_state_t nxt;
        nxt = cur;
        if (deact && cur.active)
            nxt.active = 1'b0;
        if (act && cur.pending && !cur.active) begin
            nxt.active  = 1'b1;
            nxt.pending = 1'b0;
        end
        if (set)
            nxt.pending = 1'b1;
        if (clr)
            nxt.pending = 1'b0;
        return nxt;
    endfunction

endpackage

// File: rtl/icp_decode.sv
module icp_decode
    import icp_pkg::*;
#(
    parameter int MAX_WORDS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] words_m1,
    output icp_dec_t          dec
);
    localparam logic [ADDR_W-3:0] LIMIT = (ADDR_W-2)'(MAX_WORDS);

    logic [ADDR_W-1:0] off;
    logic              in_map;

    always_comb begin
        off      = addr - ICP_BASE;
        in_map   = (addr >= ICP_BASE) && (off[ADDR_W-1:2] < LIMIT) && (off[1:0] == 2'b00);
        dec.word = off[WORD_W+1:2];
        dec.hit  = in_map && (off[WORD_W+1:2] <= words_m1);
    end
endmodule

// File: rtl/icp_access.sv
module icp_access
    import icp_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int NUM_IRQ = 32 * MAX_WORDS
) (
    input  logic [WORD_W-1:0]  words_m1,
    input  logic               affinity,
    input  logic               sec_en,
    input  logic               nonsec,
    input  logic [NUM_IRQ-1:0] ns_group,
    input  logic [NUM_IRQ-1:0] ns_ok,
    output logic [NUM_IRQ-1:0] visible,
    output logic [NUM_IRQ-1:0] writable
);
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        localparam int ID = i;
        logic impl;
        assign impl        = (WORD_W'(ID / 32) <= words_m1);
        assign visible[i]  = irq_visible(ID, impl, affinity, sec_en, nonsec,
                                         ns_group[i], ns_ok[i]);
        assign writable[i] = irq_writable(ID, visible[i]);
    end
endmodule

// File: rtl/icp_cell.sv
module icp_cell
    import icp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set,
    input  logic       act,
    input  logic       deact,
    input  logic       clr,
    output irq_state_t st
);
    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else
            st <= irq_next(st, set, act, deact, clr);
    end
endmodule

// File: rtl/icp_readmux.sv
module icp_readmux
    import icp_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int NUM_IRQ = 32 * MAX_WORDS
) (
    input  icp_dec_t           dec,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] visible,
    output logic [31:0]        word_val
);
    always_comb begin
        word_val = '0;
        for (int w = 0; w < MAX_WORDS; w++) begin
            if (dec.hit && (dec.word == WORD_W'(w)))
                word_val = pend[w*32 +: 32] & visible[w*32 +: 32];
        end
    end
endmodule

// File: rtl/icp_bank.sv
module icp_bank
    import icp_pkg::*;
#(
    parameter int MAX_WORDS = 8,
    localparam int NUM_IRQ = 32 * MAX_WORDS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [11:0]        acc_addr,
    input  logic               acc_rd,
    input  logic               acc_wr,
    input  logic [31:0]        acc_wdata,
    input  logic               acc_nonsec,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic [4:0]         cfg_words_m1,
    input  logic               cfg_sec_en,
    input  logic               cfg_affinity,
    input  logic [NUM_IRQ-1:0] irq_ns_group,
    input  logic [NUM_IRQ-1:0] irq_ns_ok,
    input  logic [NUM_IRQ-1:0] irq_set,
    input  logic [NUM_IRQ-1:0] irq_activate,
    input  logic [NUM_IRQ-1:0] irq_deactivate,
    output logic [NUM_IRQ-1:0] pend_out,
    output logic [NUM_IRQ-1:0] active_out
);
    icp_dec_t           dec;
    logic [NUM_IRQ-1:0] vis;
    logic [NUM_IRQ-1:0] wr_ok;
    logic [NUM_IRQ-1:0] clr_vec;
    logic [31:0]        word_val;

    icp_decode #(.MAX_WORDS(MAX_WORDS)) u_dec (
        .addr     (acc_addr),
        .words_m1 (cfg_words_m1),
        .dec      (dec)
    );

    icp_access #(.MAX_WORDS(MAX_WORDS)) u_acc (
        .words_m1 (cfg_words_m1),
        .affinity (cfg_affinity),
        .sec_en   (cfg_sec_en),
        .nonsec   (acc_nonsec),
        .ns_group (irq_ns_group),
        .ns_ok    (irq_ns_ok),
        .visible  (vis),
        .writable (wr_ok)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        irq_state_t st;
        assign clr_vec[i] = acc_wr && dec.hit && (dec.word == WORD_W'(i / 32))
                            && acc_wdata[i % 32] && wr_ok[i];
        icp_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set   (irq_set[i]),
            .act   (irq_activate[i]),
            .deact (irq_deactivate[i]),
            .clr   (clr_vec[i]),
            .st    (st)
        );
        assign pend_out[i]   = st.pending;
        assign active_out[i] = st.active;
    end

    icp_readmux #(.MAX_WORDS(MAX_WORDS)) u_rmux (
        .dec      (dec),
        .pend     (pend_out),
        .visible  (vis),
        .word_val (word_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_rd;
            rd_data  <= acc_rd ? word_val : 32'h0;
        end
    end
endmodule

// File: rtl/icp_bank_chk.sv
module icp_bank_chk #(
    parameter int MAX_WORDS = 8,
    localparam int NUM_IRQ = 32 * MAX_WORDS
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_rd,
    input logic               acc_nonsec,
    input logic [4:0]         cfg_words_m1,
    input logic               cfg_sec_en,
    input logic               cfg_affinity,
    input logic [NUM_IRQ-1:0] irq_ns_group,
    input logic [NUM_IRQ-1:0] irq_ns_ok,
    input logic [NUM_IRQ-1:0] irq_set,
    input logic               rd_valid,
    input logic [31:0]        rd_data,
    input logic [NUM_IRQ-1:0] pend_out,
    input logic [NUM_IRQ-1:0] clr_vec
);
    logic [NUM_IRQ-1:0] impl_mask;

    always_comb begin
        for (int w = 0; w < MAX_WORDS; w++)
            impl_mask[w*32 +: 32] = (5'(w) <= cfg_words_m1) ? 32'hFFFF_FFFF : 32'h0;
    end

    p_rd_follow_r2: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rd_valid);

    p_rd_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == 32'h0));

    p_clr_takes_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_out & $past(clr_vec)) == '0));

    p_sgi_ro_r5: assert property (@(posedge clk) disable iff (rst)
        clr_vec[15:0] == 16'h0);

    p_affinity_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_affinity |-> (clr_vec[31:0] == 32'h0));

    p_unimpl_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_vec & ~impl_mask) == '0);

    p_nonsec_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_sec_en && acc_nonsec) |-> ((clr_vec & ~(irq_ns_group | irq_ns_ok)) == '0));

    p_set_lands_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_out & $past(irq_set & ~clr_vec)) == $past(irq_set & ~clr_vec)));
endmodule

bind icp_bank icp_bank_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_rd       (acc_rd),
    .acc_nonsec   (acc_nonsec),
    .cfg_words_m1 (cfg_words_m1),
    .cfg_sec_en   (cfg_sec_en),
    .cfg_affinity (cfg_affinity),
    .irq_ns_group (irq_ns_group),
    .irq_ns_ok    (irq_ns_ok),
    .irq_set      (irq_set),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .pend_out     (pend_out),
    .clr_vec      (clr_vec)
);

// File: tb/sim_icp_bank.sv
module sim_icp_bank;
    localparam int MW = 2;
    localparam int NI = 32 * MW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   acc_addr = '0;
    logic          acc_rd = 1'b0;
    logic          acc_wr = 1'b0;
    logic [31:0]   acc_wdata = '0;
    logic          acc_nonsec = 1'b0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [4:0]    cfg_words_m1 = 5'd1;
    logic          cfg_sec_en = 1'b0;
    logic          cfg_affinity = 1'b0;
    logic [NI-1:0] irq_ns_group = '0;
    logic [NI-1:0] irq_ns_ok = '0;
    logic [NI-1:0] irq_set = '0;
    logic [NI-1:0] irq_activate = '0;
    logic [NI-1:0] irq_deactivate = '0;
    logic [NI-1:0] pend_out;
    logic [NI-1:0] active_out;

    icp_bank #(.MAX_WORDS(MW)) u0 (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_nonsec(acc_nonsec), .rd_valid(rd_valid),
        .rd_data(rd_data), .cfg_words_m1(cfg_words_m1), .cfg_sec_en(cfg_sec_en),
        .cfg_affinity(cfg_affinity), .irq_ns_group(irq_ns_group), .irq_ns_ok(irq_ns_ok),
        .irq_set(irq_set), .irq_activate(irq_activate), .irq_deactivate(irq_deactivate),
        .pend_out(pend_out), .active_out(active_out)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [NI-1:0] mp = '0;
    logic [NI-1:0] ma = '0;

    function automatic int m_word(input logic [11:0] a);
        int off;
        off = int'(a) - 'h280;
        if (off < 0 || off >= 4 * MW || (off % 4) != 0) return -1;
        if (off / 4 > int'(cfg_words_m1)) return -1;
        return off / 4;
    endfunction

    function automatic bit m_vis(input int i, input bit ns);
        if (cfg_affinity && i < 32) return 0;
        if (i / 32 > int'(cfg_words_m1)) return 0;
        if (cfg_sec_en && ns && !irq_ns_group[i] && !irq_ns_ok[i]) return 0;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic [NI-1:0] np, na;
        int w;
        np = mp; na = ma;
        w = m_word(acc_addr);
        for (int i = 0; i < NI; i++) begin
            bit cl;
            cl = acc_wr && (w >= 0) && (i / 32 == w) && acc_wdata[i % 32]
                 && m_vis(i, acc_nonsec) && (i >= 16);
            if (irq_deactivate[i] && ma[i]) na[i] = 1'b0;
            if (irq_activate[i] && mp[i] && !ma[i]) begin na[i] = 1'b1; np[i] = 1'b0; end
            if (irq_set[i]) np[i] = 1'b1;
            if (cl) np[i] = 1'b0;
        end
        @(posedge clk);
        if (rst) begin mp = '0; ma = '0; end
        else begin mp = np; ma = na; end
        @(negedge clk);
    endtask

    task automatic st_chk(input string req);
        chk(pend_out == mp, {req, " pending"}, 64'(pend_out), 64'(mp));
        chk(active_out == ma, {req, " active"}, 64'(active_out), 64'(ma));
    endtask

    task automatic rd_chk(input logic [11:0] a, input bit ns, input string req);
        logic [31:0] exp;
        int w;
        w = m_word(a);
        exp = '0;
        for (int b = 0; b < 32; b++)
            if (w >= 0) exp[b] = mp[w*32+b] & m_vis(w*32+b, ns);
        acc_addr = a; acc_rd = 1'b1; acc_nonsec = ns;
        tick();
        acc_rd = 1'b0;
        chk(rd_valid === 1'b1, {req, " rd_valid"}, 64'(rd_valid), 64'd1);
        chk(rd_data === exp, {req, " rd_data"}, 64'(rd_data), 64'(exp));
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit ns);
        acc_addr = a; acc_wdata = d; acc_wr = 1'b1; acc_nonsec = ns;
        tick();
        acc_wr = 1'b0; acc_wdata = '0;
    endtask

    task automatic set_all();
        irq_set = '1; tick(); irq_set = '0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual %h expected %h", 64'd0, 64'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R4: reset state
        st_chk("R4");
        rd_chk(12'h280, 0, "R4");
        rd_chk(12'h284, 0, "R4");
        chk(rd_valid == 1'b1 && $isunknown(rd_data) == 0, "R4 clean", 64'(rd_valid), 64'd1);
        tick();
        chk(rd_valid == 1'b0 && rd_data == 32'h0, "R2 idle", 64'(rd_data), 64'd0);

        // R10/R2/R1: everything pending, both words read ones
        set_all();
        st_chk("R10 set");
        rd_chk(12'h280, 0, "R2 R1");
        rd_chk(12'h284, 0, "R2 R1");

        // R3/R1/R5: walking one-hot clear
        for (int m = 0; m < NI; m++) begin
            wr(12'(12'h280 + 4 * (m / 32)), 32'(1) << (m % 32), 0);
            st_chk(m < 16 ? "R5 sgi" : "R3 R1 walk");
        end
        rd_chk(12'h280, 0, "R5 read");
        chk(rd_data == 32'h0000_FFFF, "R5 value", 64'(rd_data), 64'h0000_FFFF);

        // R3: write zero has no effect
        set_all();
        wr(12'h284, 32'h0, 0);
        st_chk("R3 zero");

        // R10/R3: active and active-and-pending
        irq_activate = '1; tick(); irq_activate = '0;
        st_chk("R10 activate");
        rd_chk(12'h284, 0, "R2 active");
        set_all();
        st_chk("R10 act+pend");
        rd_chk(12'h284, 0, "R2 act+pend");
        wr(12'h284, 32'hFFFF_FFFF, 0);
        st_chk("R3 act+pend clear");
        wr(12'h284, 32'hA5A5_A5A5, 0);
        st_chk("R3 active untouched");
        set_all();
        irq_deactivate = '1; tick(); irq_deactivate = '0;
        st_chk("R10 deactivate");
        irq_deactivate = '1; tick(); irq_deactivate = '0;
        wr(12'h280, 32'hFFFF_FFFF, 0);
        wr(12'h284, 32'hFFFF_FFFF, 0);
        st_chk("R3 to inactive");

        // R6: affinity routing
        set_all();
        cfg_affinity = 1'b1;
        rd_chk(12'h280, 0, "R6");
        chk(rd_data == 32'h0, "R6 raz", 64'(rd_data), 64'd0);
        rd_chk(12'h284, 0, "R6 upper");
        wr(12'h280, 32'hFFFF_FFFF, 0);
        st_chk("R6 wi");
        cfg_affinity = 1'b0;

        // R7: unimplemented word and stray addresses
        cfg_words_m1 = 5'd0;
        rd_chk(12'h284, 0, "R7 unimpl");
        wr(12'h284, 32'hFFFF_FFFF, 0);
        st_chk("R7 unimpl wi");
        cfg_words_m1 = 5'd1;
        rd_chk(12'h288, 0, "R7 beyond");
        rd_chk(12'h285, 0, "R7 misaligned");
        rd_chk(12'h200, 0, "R7 below");
        wr(12'h286, 32'hFFFF_FFFF, 0);
        wr(12'h27C, 32'hFFFF_FFFF, 0);
        st_chk("R7 stray wi");

        // R8: security masking
        cfg_sec_en = 1'b1;
        irq_ns_group = {MW{32'h5555_5555}};
        irq_ns_ok    = {MW{32'h00FF_0000}};
        rd_chk(12'h284, 1, "R8 ns read");
        rd_chk(12'h284, 0, "R8 s read");
        wr(12'h284, 32'hFFFF_FFFF, 1);
        st_chk("R8 ns write");
        wr(12'h284, 32'hFFFF_FFFF, 0);
        st_chk("R8 s write");
        cfg_sec_en = 1'b0;
        irq_ns_group = '0; irq_ns_ok = '0;
        wr(12'h280, 32'hFFFF_FFFF, 0);

        // R9: set and clear collide
        irq_set[40] = 1'b1;
        wr(12'h284, 32'h0000_0100, 0);
        st_chk("R9 clear wins");
        tick();
        irq_set[40] = 1'b0;
        st_chk("R9 set next");
        chk(pend_out[40] == 1'b1, "R9 pending", 64'(pend_out[40]), 64'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule